// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is the target (slave) side of a two-wire serial bus. It watches the clock and data lines, both open-drain, through a synchronizer. It detects START and STOP conditions and compares the first address byte with a programmed own address. The address can be 7-bit, or 10-bit carried in two bytes. It can also answer the all-zero general call address when the host permits it. After a match it either receives data bytes or sends them, most significant bit first, and takes part in the acknowledge slot on the ninth clock.

Received bytes go to the host over a valid/ready stream. `rx_valid` rises after a byte and holds with `rx_data` stable until a cycle with `rx_ready` high. Until that cycle the engine holds SCL low, so a slow host back-pressures the bus master and no byte is ever lost. Bytes to transmit come in on a second valid/ready stream. `tx_ready` is high while the engine holds SCL low before a byte, and a cycle with `tx_valid` high hands over `tx_data`. The host may hold off `tx_valid` for as long as it likes: the bus waits. Configuration and status are plain level pins.

Top module: `i2c_slave_stretch`

## Requirements
- R1: After reset both line drivers are released (`scl_oe`=0, `sda_oe`=0), `tx_ready`=0, `rx_valid`=0 and every status flag is 0.
- R2: Data bits are shifted MSB first in both directions, and received bytes reach the host in bus order.
- R3: In 7-bit mode (`cfg_addr10`=0) a first byte whose upper seven bits equal `cfg_own_addr[6:0]` is acknowledged with SDA low on the 9th clock, and `sts_addressed` rises. Bit 0 of that byte selects read (1) or write (0) and appears on `sts_read`. Any other byte is not acknowledged, and the engine ignores the bus until the next START or STOP.
- R4: The byte 0x00 is acknowledged as a general call only while `cfg_gc_en`=1, and it sets `sts_gencall`. With `cfg_gc_en`=0 it is not acknowledged.
- R5: In a write transfer each received byte raises `rx_valid`. After the 9th clock the engine holds SCL low until the `rx_valid`/`rx_ready` handshake, and it starts stretching only while SCL is already low.
- R6: With `cfg_ack_en`=0, address bytes are not acknowledged and the engine stays unaddressed. A data byte in a transfer that is already addressed is still delivered on the rx stream, but SDA stays high on its 9th clock.
- R7: In a read transfer the engine holds SCL low with `tx_ready`=1 before every byte until the host presents `tx_valid`. It then sends that byte.
- R8: When the master leaves SDA high on the 9th clock after a sent byte, `sts_nack` is set, SDA is released and `tx_ready` stays 0 until the next START.
- R9: In 10-bit mode the first byte must be 1111_0 followed by `cfg_own_addr[9:8]` and R/W=0, and the second byte must equal `cfg_own_addr[7:0]`. Both are acknowledged and the engine is then addressed for writing. A wrong second byte is not acknowledged.
- R10: After a full 10-bit write match, a repeated START followed by the header byte with R/W=1 is acknowledged and starts a read. The same header with no earlier match in that transfer is not acknowledged.
- R11: START and STOP are recognized in every state, including mid-byte. They clear `sts_addressed`, and the next address byte is decoded afresh.
- R12: The engine changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_own_addr | input | ADDR_W | Own address (low 7 bits used in 7-bit mode) |
| cfg_addr10 | input | 1 | 1 selects 10-bit addressing |
| cfg_gc_en | input | 1 | 1 lets the engine answer the general call |
| cfg_ack_en | input | 1 | 1 lets the engine acknowledge |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Engine is waiting for a byte to send |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | rx_data holds an unread byte |
| rx_ready | input | 1 | Host takes rx_data |
| sts_addressed | output | 1 | Engine is selected in the current transfer |
| sts_read | output | 1 | Selected for reading |
| sts_gencall | output | 1 | Selected by the general call |
| sts_nack | output | 1 | Master refused the last byte sent |

## Verification
A level change on a bus line passes two synchronizer flops and one edge register. The state, and with it `sda_oe`, `scl_oe` and `tx_ready`, therefore changes on the third clock edge after the change. Status flags follow the SCL fall that ends an address byte by the same three cycles. The bench master keeps each SCL phase ten clocks long and reads SDA and status at the end of a phase, so every sample falls well after the result is due. The host models wait a fixed 60 or 30 cycles before completing a handshake, which forces stretching. A per-clock monitor compares SDA drive changes against the line state one clock earlier.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_ADDR2, S_A2ACK,
    S_RX, S_RACK, S_RHOLD,
    S_TXHOLD, S_TXSET, S_TX, S_TACK, S_WAIT
  } st_e;

  typedef struct packed {
    logic own7;   // 7-bit own address hit
    logic hdr_w;  // 10-bit header, write
    logic hdr_r;  // 10-bit header, read, after earlier full match
    logic gcall;  // general call hit
  } match_t;
endpackage

// File: rtl/i2cs_linesync.sv
module i2cs_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] last_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '1;
    else        last_q <= synced;
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~last_q[0];
  assign scl_fall  = ~synced[0] & last_q[0];
  assign start_evt = synced[0] & last_q[0] & last_q[1] & ~synced[1];
  assign stop_evt  = synced[0] & last_q[0] & ~last_q[1] & synced[1];
endmodule

// File: rtl/i2cs_shifter.sv
module i2cs_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         capture,
  input  logic         din,
  input  logic         tick,
  input  logic         advance,
  output logic [W-1:0] sr,
  output logic         full
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(W);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (load) begin
      sr  <= load_val;
      cnt <= '0;
    end else if (capture) begin
      sr  <= {sr[W-2:0], din};
      cnt <= cnt + 1'b1;
    end else begin
      if (tick)    cnt <= cnt + 1'b1;
      if (advance) sr  <= {sr[W-2:0], 1'b0};
    end
  end

  assign full = (cnt == FULL_CNT);
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [ADDR_W-1:0] own,
  input  logic              mode10,
  input  logic              gc_en,
  input  logic              hdr_ok,
  output match_t            m,
  output logic              low_hit
);
  localparam logic [4:0] HDR_TAG = 5'b11110;

  logic hdr;

  always_comb begin
    hdr     = mode10 && (rx_byte[7:3] == HDR_TAG) && (rx_byte[2:1] == own[ADDR_W-1 -: 2]);
    m.own7  = !mode10 && (rx_byte[7:1] == own[6:0]);
    m.hdr_w = hdr && !rx_byte[0];
    m.hdr_r = hdr && rx_byte[0] && hdr_ok;
    m.gcall = gc_en && (rx_byte == '0);
    low_hit = (rx_byte == own[7:0]);
  end
endmodule

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch
  import i2cs_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_addr10,
  input  logic              cfg_gc_en,
  input  logic              cfg_ack_en,
  input  logic [7:0]        tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              sts_addressed,
  output logic              sts_read,
  output logic              sts_gencall,
  output logic              sts_nack
);
  st_e  st;
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [BYTE_W-1:0] sr;
  logic full;
  logic sh_clr, sh_load, sh_cap, sh_tick, sh_adv;
  match_t m;
  logic low_hit, any_hit;
  logic hdr_ok, need2, ack_now, macked;

  i2cs_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cs_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(sh_load), .load_val(tx_data),
    .capture(sh_cap), .din(sda_s), .tick(sh_tick), .advance(sh_adv),
    .sr(sr), .full(full)
  );

  i2cs_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .rx_byte(sr), .own(cfg_own_addr), .mode10(cfg_addr10), .gc_en(cfg_gc_en),
    .hdr_ok(hdr_ok), .m(m), .low_hit(low_hit)
  );

  assign any_hit = m.own7 | m.gcall | m.hdr_w | m.hdr_r;

  // shifter control
  always_comb begin
    sh_clr  = start_evt | stop_evt |
              (scl_fall && (st inside {S_AACK, S_A2ACK, S_RACK}));
    sh_load = (st == S_TXHOLD) && tx_valid && !start_evt && !stop_evt;
    sh_cap  = scl_rise && !full && (st inside {S_ADDR, S_ADDR2, S_RX});
    sh_tick = scl_rise && (st == S_TX);
    sh_adv  = scl_fall && !full && (st == S_TX);
  end

  // line drivers and stream ready
  always_comb begin
    scl_oe   = (st == S_TXHOLD) || (st == S_TXSET) || ((st == S_RHOLD) && rx_valid);
    sda_oe   = (st == S_AACK) || (st == S_A2ACK) || ((st == S_RACK) && ack_now) ||
               (((st == S_TXSET) || (st == S_TX)) && !sr[BYTE_W-1]);
    tx_ready = (st == S_TXHOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      rx_data       <= '0;
      rx_valid      <= 1'b0;
      sts_addressed <= 1'b0;
      sts_read      <= 1'b0;
      sts_gencall   <= 1'b0;
      sts_nack      <= 1'b0;
      hdr_ok        <= 1'b0;
      need2         <= 1'b0;
      ack_now       <= 1'b0;
      macked        <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;

      if (stop_evt) begin
        st            <= S_IDLE;
        sts_addressed <= 1'b0;
        sts_read      <= 1'b0;
        sts_gencall   <= 1'b0;
        hdr_ok        <= 1'b0;
      end else if (start_evt) begin
        st            <= S_ADDR;
        sts_addressed <= 1'b0;
        sts_read      <= 1'b0;
        sts_gencall   <= 1'b0;
        sts_nack      <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR: if (scl_fall && full) begin
            if (cfg_ack_en && any_hit) begin
              st            <= S_AACK;
              need2         <= m.hdr_w;
              sts_addressed <= !m.hdr_w;
              sts_read      <= m.hdr_r | (m.own7 & sr[0]);
              sts_gencall   <= m.gcall;
              hdr_ok        <= m.hdr_r;
            end else begin
              st     <= S_WAIT;
              hdr_ok <= 1'b0;
            end
          end
          S_AACK: if (scl_fall) begin
            if (need2)         st <= S_ADDR2;
            else if (sts_read) st <= S_TXHOLD;
            else               st <= S_RX;
          end
          S_ADDR2: if (scl_fall && full) begin
            if (cfg_ack_en && low_hit) begin
              st            <= S_A2ACK;
              hdr_ok        <= 1'b1;
              sts_addressed <= 1'b1;
            end else begin
              st <= S_WAIT;
            end
          end
          S_A2ACK: if (scl_fall) st <= S_RX;
          S_RX: if (scl_fall && full) begin
            rx_data  <= sr;
            rx_valid <= 1'b1;
            ack_now  <= cfg_ack_en;
            st       <= S_RACK;
          end
          S_RACK:   if (scl_fall) st <= S_RHOLD;
          S_RHOLD:  if (!rx_valid || rx_ready) st <= S_RX;
          S_TXHOLD: if (tx_valid) st <= S_TXSET;
          S_TXSET:  st <= S_TX;
          S_TX:     if (scl_fall && full) st <= S_TACK;
          S_TACK: begin
            if (scl_rise) macked <= !sda_s;
            if (scl_fall) begin
              if (macked) st <= S_TXHOLD;
              else begin
                st       <= S_WAIT;
                sts_nack <= 1'b1;
              end
            end
          end
          S_IDLE, S_WAIT: ;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_sync,
  input logic start_evt,
  input logic stop_evt,
  input logic scl_oe,
  input logic sda_oe,
  input logic rx_valid,
  input logic rx_ready,
  input logic tx_valid,
  input logic tx_ready,
  input logic sts_addressed,
  input logic sts_gencall,
  input logic sts_nack,
  input logic cfg_gc_en
);
  // R12: SDA drive changes only after a cycle with SCL seen low
  p_sda_low_scl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_sync));

  // R5: stretching begins only while SCL is already low
  p_stretch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !$past(scl_sync));

  // R5: a received byte stays offered until taken
  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R7: the request for a byte stays up until served
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> tx_ready);

  // R8: no further byte requests after a master refusal
  p_nack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sts_nack |-> !tx_ready);

  // R11: START or STOP drops the selection
  p_cond_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !sts_addressed);

  // R4: general call selection only while enabled
  p_gc_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_gencall) |-> $past(cfg_gc_en));
endmodule

bind i2c_slave_stretch i2cs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_sync(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .sts_addressed(sts_addressed), .sts_gencall(sts_gencall), .sts_nack(sts_nack),
  .cfg_gc_en(cfg_gc_en)
);

// File: tb/sim_i2c_slave_stretch.sv
module sim_i2c_slave_stretch;
  localparam int H        = 10;
  localparam int RX_DELAY = 60;
  localparam int TX_DELAY = 30;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe;
  logic [9:0] cfg_own_addr = 10'h05A;
  logic cfg_addr10 = 1'b0, cfg_gc_en = 1'b0, cfg_ack_en = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] rx_data;
  logic rx_valid, rx_ready = 1'b0;
  logic sts_addressed, sts_read, sts_gencall, sts_nack;

  wire scl_line = m_scl & ~scl_oe;
  wire sda_line = m_sda & ~sda_oe;

  i2c_slave_stretch u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_own_addr(cfg_own_addr),
    .cfg_addr10(cfg_addr10), .cfg_gc_en(cfg_gc_en), .cfg_ack_en(cfg_ack_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sts_addressed(sts_addressed), .sts_read(sts_read),
    .sts_gencall(sts_gencall), .sts_nack(sts_nack)
  );

  int errs = 0, checks = 0;
  int stretch_tot = 0;
  int r12_bad = 0;
  int rx_wait = 0, tx_wait = 0;
  logic [7:0] got_q[$];
  logic [7:0] tx_q[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // host model: reads and writes after fixed delays
  always @(negedge clk) begin
    if (rx_ready) rx_ready = 1'b0;
    else if (rx_valid) begin
      if (rx_wait >= RX_DELAY) begin
        rx_ready = 1'b1;
        got_q.push_back(rx_data);
        rx_wait = 0;
      end else rx_wait++;
    end
    if (tx_valid) tx_valid = 1'b0;
    else if (tx_ready && tx_q.size() > 0) begin
      if (tx_wait >= TX_DELAY) begin
        tx_data  = tx_q.pop_front();
        tx_valid = 1'b1;
        tx_wait  = 0;
      end else tx_wait++;
    end
  end

  // per-clock reference: SDA drive may change only with SCL low (R12)
  logic p_line_scl = 1'b1, p_sda_oe = 1'b0;
  always @(posedge clk) begin
    if (rst_n && p_line_scl && scl_line && (sda_oe !== p_sda_oe)) r12_bad++;
    p_line_scl = scl_line;
    p_sda_oe   = sda_oe;
  end

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic rel_scl();
    int n = 0;
    m_scl = 1'b1;
    #1;
    while (scl_line !== 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 4000) chk("R5 SCL never released", 0, 1);
    stretch_tot += n;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hw();
    rel_scl(); hw();
    m_sda = 1'b0; hw();
    m_scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw();
    rel_scl(); hw();
    m_sda = 1'b1; hw();
  endtask

  task automatic bit_x(input logic b, output logic r);
    m_sda = b; hw();
    rel_scl(); hw();
    r = sda_line;
    m_scl = 1'b0; hw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    acked = !r;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic r;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_x(1'b1, r);
      b = {b[6:0], r};
    end
    bit_x(!ack, r);
  endtask

  task automatic expect_got(string tag, logic [7:0] exp[$]);
    repeat (RX_DELAY + 40) @(negedge clk);
    chk({tag, " count"}, got_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got_q.size(); i++)
      chk({tag, " data"}, got_q[i], exp[i]);
    got_q.delete();
  endtask

  initial begin
    repeat (20000 * 9) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    int s0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 tx_ready", tx_ready, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 status", {sts_addressed, sts_read, sts_gencall, sts_nack}, 0);
    rst_n = 1'b1;
    hw();

    // 7-bit write, own address 0x5A -> byte 0xB4
    s0 = stretch_tot;
    bus_start();
    send_byte(8'hB4, a); chk("R3 own addr ack", a, 1);
    chk("R3 addressed", sts_addressed, 1);
    chk("R3 read flag", sts_read, 0);
    send_byte(8'hA5, a); chk("R5 data ack", a, 1);
    send_byte(8'h3C, a); chk("R5 data ack 2", a, 1);
    bus_stop();
    expect_got("R2 rx order", '{8'hA5, 8'h3C});
    chk("R5 stretch seen", int'(stretch_tot > s0), 1);
    chk("R11 stop clears addressed", sts_addressed, 0);

    // wrong address 0x5B
    bus_start();
    send_byte(8'hB6, a); chk("R3 foreign addr nack", a, 0);
    send_byte(8'h11, a); chk("R3 ignored data nack", a, 0);
    bus_stop();
    expect_got("R3 nothing received", '{});

    // general call enabled / disabled
    cfg_gc_en = 1'b1;
    bus_start();
    send_byte(8'h00, a); chk("R4 gc ack", a, 1);
    chk("R4 gencall flag", sts_gencall, 1);
    send_byte(8'h77, a);
    bus_stop();
    expect_got("R4 gc data", '{8'h77});
    cfg_gc_en = 1'b0;
    bus_start();
    send_byte(8'h00, a); chk("R4 gc disabled nack", a, 0);
    chk("R4 gencall flag off", sts_gencall, 0);
    bus_stop();

    // acknowledge disabled
    cfg_ack_en = 1'b0;
    bus_start();
    send_byte(8'hB4, a); chk("R6 addr nack", a, 0);
    chk("R6 not addressed", sts_addressed, 0);
    bus_stop();
    cfg_ack_en = 1'b1;
    bus_start();
    send_byte(8'hB4, a); chk("R6 addr ack", a, 1);
    cfg_ack_en = 1'b0;
    send_byte(8'h5E, a); chk("R6 data nack", a, 0);
    cfg_ack_en = 1'b1;
    bus_stop();
    expect_got("R6 data still delivered", '{8'h5E});

    // 7-bit read
    s0 = stretch_tot;
    tx_q.push_back(8'h96);
    tx_q.push_back(8'h0F);
    bus_start();
    send_byte(8'hB5, a); chk("R7 read addr ack", a, 1);
    chk("R7 read flag", sts_read, 1);
    recv_byte(1'b1, d); chk("R7 byte 0 MSB first", d, 8'h96);
    recv_byte(1'b0, d); chk("R7 byte 1", d, 8'h0F);
    repeat (3 * H) @(negedge clk);
    chk("R8 nack flag", sts_nack, 1);
    chk("R8 no tx request", tx_ready, 0);
    chk("R8 SDA released", sda_oe, 0);
    bus_stop();
    chk("R7 stretch seen", int'(stretch_tot > s0), 1);

    // 10-bit write, own 0x2B7: header 0xF4, low 0xB7
    cfg_addr10 = 1'b1;
    cfg_own_addr = 10'h2B7;
    bus_start();
    send_byte(8'hF4, a); chk("R9 header ack", a, 1);
    send_byte(8'hB7, a); chk("R9 low byte ack", a, 1);
    chk("R9 addressed", sts_addressed, 1);
    send_byte(8'hC3, a); chk("R9 data ack", a, 1);
    bus_stop();
    expect_got("R9 data", '{8'hC3});
    bus_start();
    send_byte(8'hF4, a);
    send_byte(8'hB8, a); chk("R9 wrong low nack", a, 0);
    bus_stop();

    // 10-bit read via repeated START
    bus_start();
    send_byte(8'hF5, a); chk("R10 bare read header nack", a, 0);
    bus_stop();
    tx_q.push_back(8'h5A);
    bus_start();
    send_byte(8'hF4, a);
    send_byte(8'hB7, a);
    bus_start();
    send_byte(8'hF5, a); chk("R10 read header ack", a, 1);
    chk("R10 read flag", sts_read, 1);
    recv_byte(1'b0, d); chk("R10 read data", d, 8'h5A);
    bus_stop();

    // STOP in the middle of a byte
    cfg_addr10 = 1'b0;
    cfg_own_addr = 10'h05A;
    bus_start();
    send_byte(8'hB4, a);
    bit_x(1'b1, a); bit_x(1'b0, a); bit_x(1'b1, a);
    bus_stop();
    chk("R11 mid-byte stop clears", sts_addressed, 0);
    bus_start();
    send_byte(8'hB4, a); chk("R11 restart addr ack", a, 1);
    send_byte(8'h42, a);
    bus_stop();
    expect_got("R11 fresh transfer", '{8'h42});

    chk("R12 SDA changes with SCL high", r12_bad, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule